// File: doc/BRIEF.md
# Bridge I/O Window Decoder

This block decides which processor I/O cycles a host-to-downstream-link bridge claims. Two byte-wide configuration registers hold the bottom and the top of a window in the 64 KB I/O space. Only the upper nibble of each register can be programmed, so the window is a whole number of 4 KB blocks. The bottom is formed by filling the twelve low address bits with zeros. The top is formed by filling them with ones.

Software reaches the registers through a plain byte-wide configuration port. Writes are registered on the clock edge, and reads are combinational. Each I/O cycle shows up as a 16-bit address qualified by a valid strobe. The block raises its forward flag in the same cycle when the address lies inside the window, and both ends of the window count as inside. The I/O side applies no back-pressure. It has no ready signal, because the decoder can judge an address in every cycle.

The reset values put the window bottom above the window top. The window is therefore empty and nothing is forwarded until software programs the registers.

Top module: `iowin_decoder`

## Requirements
- R1: After reset, a read at offset 1Ch returns F0h and a read at offset 1Dh returns 00h.
- R2: With cfg_wr_en high, cfg_wdata[7:4] is stored into the register selected by cfg_addr (1Ch is the window bottom, 1Dh is the window top) on the rising clock edge, and it is visible on cfg_rdata[7:4] from that edge on.
- R3: Bits 3:0 of both registers are reserved: write data on those bits is ignored and they always read back as zero.
- R4: A read at any offset other than 1Ch or 1Dh returns 00h, and a write to such an offset changes neither register.
- R5: io_fwd is low whenever io_valid is low, whatever the address.
- R6: The window bottom is inclusive: address {base[7:4], 000h} is forwarded, and the address one below it is not.
- R7: The window top is inclusive: address {limit[7:4], FFFh} is forwarded, and the address one above it is not.
- R8: When the bottom nibble is greater than the top nibble, including the reset state, io_fwd stays low for every address.
- R9: With the bottom register programmed to 00h, the addresses 0CF8h and 0CFCh are forwarded like any other in-range address.
- R10: io_fwd follows io_addr and io_valid combinationally, in the same cycle and with no clock edge in between.
- R11: Reset is synchronous and active-high, and it returns both registers to their defaults after they have been programmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Combinational read data for cfg_addr |
| io_valid | input | 1 | An I/O cycle is present this cycle |
| io_addr | input | 16 | I/O cycle address |
| io_fwd | output | 1 | I/O cycle falls inside the window |

## Verification
The assertions assume that io_addr is only meaningful while io_valid is high. They also assume that a configuration write and reset never coincide in a way that matters: reset wins, and the write-capture check is masked in that cycle. The stimulus drives all inputs on the falling edge, holds reset for whole cycles, and only moves io_addr inside a half cycle in the test for same-cycle response. The bench leaves cfg_wr_en low while it probes the window, so that every probe runs against a settled pair of registers.

// File: rtl/iowin_pkg.sv
package iowin_pkg;
  // Register slots within the window register file; the order fixes which
  // slot is the window bottom and which is the window top.
  localparam int unsigned NUM_WIN_REGS = 2;
  localparam int unsigned SLOT_BOTTOM  = 0;
  localparam int unsigned SLOT_TOP     = 1;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_BOTTOM = 2'd1,
    RD_TOP    = 2'd2
  } iowin_rd_sel_e;
endpackage

// File: rtl/iowin_cfg_regs.sv
module iowin_cfg_regs
  import iowin_pkg::*;
#(
  parameter int unsigned CFG_AW     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PROG_W     = 4,
  parameter logic [CFG_AW-1:0] BOTTOM_OFS = 8'h1C,
  parameter logic [CFG_AW-1:0] TOP_OFS    = 8'h1D,
  parameter logic [DATA_W-1:0] BOTTOM_RST = 8'hF0,
  parameter logic [DATA_W-1:0] TOP_RST    = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [PROG_W-1:0] bottom_prog,
  output logic [PROG_W-1:0] top_prog
);
  localparam int unsigned RSV_W = DATA_W - PROG_W;

  logic [PROG_W-1:0]       prog_q [NUM_WIN_REGS];
  logic [NUM_WIN_REGS-1:0] hit;
  iowin_rd_sel_e           rd_sel;

  // One programmable nibble per slot; offset and reset value picked per slot.
  for (genvar s = 0; s < NUM_WIN_REGS; s++) begin : g_slot
    localparam logic [CFG_AW-1:0] OFS  = (s == SLOT_BOTTOM) ? BOTTOM_OFS : TOP_OFS;
    localparam logic [DATA_W-1:0] RSTV = (s == SLOT_BOTTOM) ? BOTTOM_RST : TOP_RST;

    assign hit[s] = (addr == OFS);

    always_ff @(posedge clk) begin
      if (rst) begin
        prog_q[s] <= RSTV[DATA_W-1 -: PROG_W];
      end else if (wr_en && hit[s]) begin
        prog_q[s] <= wdata[DATA_W-1 -: PROG_W];
      end
    end
  end

  always_comb begin
    rd_sel = RD_NONE;
    if (hit[SLOT_BOTTOM]) begin
      rd_sel = RD_BOTTOM;
    end else if (hit[SLOT_TOP]) begin
      rd_sel = RD_TOP;
    end
  end

  always_comb begin
    unique case (rd_sel)
      RD_BOTTOM: rdata = {prog_q[SLOT_BOTTOM], {RSV_W{1'b0}}};
      RD_TOP:    rdata = {prog_q[SLOT_TOP], {RSV_W{1'b0}}};
      default:   rdata = '0;
    endcase
  end

  assign bottom_prog = prog_q[SLOT_BOTTOM];
  assign top_prog    = prog_q[SLOT_TOP];
endmodule

// File: rtl/iowin_range_cmp.sv
module iowin_range_cmp #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned GRAN_BITS = 12,
  parameter int unsigned PROG_W    = ADDR_W - GRAN_BITS
) (
  input  logic [PROG_W-1:0] bottom_prog,
  input  logic [PROG_W-1:0] top_prog,
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  output logic              fwd
);
  logic [ADDR_W-1:0] win_lo;
  logic [ADDR_W-1:0] win_hi;
  logic              above_lo;
  logic              below_hi;

  // Bottom fills the granule with zeros, top fills it with ones.
  assign win_lo = {bottom_prog, {GRAN_BITS{1'b0}}};
  assign win_hi = {top_prog, {GRAN_BITS{1'b1}}};

  assign above_lo = (addr >= win_lo);
  assign below_hi = (addr <= win_hi);

  // An inverted window can satisfy neither bound together, so it is empty.
  assign fwd = valid & above_lo & below_hi;
endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder #(
  parameter int unsigned CFG_AW    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned GRAN_BITS = 12,
  parameter logic [CFG_AW-1:0] BOTTOM_OFS = 8'h1C,
  parameter logic [CFG_AW-1:0] TOP_OFS    = 8'h1D,
  parameter logic [DATA_W-1:0] BOTTOM_RST = 8'hF0,
  parameter logic [DATA_W-1:0] TOP_RST    = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              io_valid,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              io_fwd
);
  localparam int unsigned PROG_W = ADDR_W - GRAN_BITS;

  logic [PROG_W-1:0] bottom_prog;
  logic [PROG_W-1:0] top_prog;

  iowin_cfg_regs #(
    .CFG_AW     (CFG_AW),
    .DATA_W     (DATA_W),
    .PROG_W     (PROG_W),
    .BOTTOM_OFS (BOTTOM_OFS),
    .TOP_OFS    (TOP_OFS),
    .BOTTOM_RST (BOTTOM_RST),
    .TOP_RST    (TOP_RST)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (cfg_wr_en),
    .addr        (cfg_addr),
    .wdata       (cfg_wdata),
    .rdata       (cfg_rdata),
    .bottom_prog (bottom_prog),
    .top_prog    (top_prog)
  );

  iowin_range_cmp #(
    .ADDR_W    (ADDR_W),
    .GRAN_BITS (GRAN_BITS),
    .PROG_W    (PROG_W)
  ) u_cmp (
    .bottom_prog (bottom_prog),
    .top_prog    (top_prog),
    .valid       (io_valid),
    .addr        (io_addr),
    .fwd         (io_fwd)
  );
endmodule

// File: rtl/iowin_decoder_chk.sv
module iowin_decoder_chk #(
  parameter int unsigned CFG_AW = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PROG_W = 4,
  parameter logic [CFG_AW-1:0] BOTTOM_OFS = 8'h1C,
  parameter logic [CFG_AW-1:0] TOP_OFS    = 8'h1D,
  parameter logic [DATA_W-1:0] BOTTOM_RST = 8'hF0,
  parameter logic [DATA_W-1:0] TOP_RST    = 8'h00
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr_en,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              io_valid,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_fwd,
  input logic [PROG_W-1:0] bottom_prog,
  input logic [PROG_W-1:0] top_prog
);
  localparam int unsigned RSV_W = DATA_W - PROG_W;
  localparam logic [PROG_W-1:0] BOT_RST_HI = BOTTOM_RST[DATA_W-1 -: PROG_W];
  localparam logic [PROG_W-1:0] TOP_RST_HI = TOP_RST[DATA_W-1 -: PROG_W];

  AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bottom_prog == BOT_RST_HI && top_prog == TOP_RST_HI)); // R1

  AST_WRITE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_wr_en) && !$past(rst) && $past(cfg_addr) == BOTTOM_OFS)
      |-> (bottom_prog == $past(cfg_wdata[DATA_W-1 -: PROG_W]))); // R2

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[RSV_W-1:0] == '0); // R3

  AST_OTHER_OFS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cfg_addr != BOTTOM_OFS && cfg_addr != TOP_OFS) |-> cfg_rdata == '0); // R4

  AST_NO_FWD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !io_valid |-> !io_fwd); // R5

  AST_FWD_INSIDE: assert property (@(posedge clk) disable iff (rst)
    io_fwd |-> (io_addr[ADDR_W-1 -: PROG_W] >= bottom_prog &&
                io_addr[ADDR_W-1 -: PROG_W] <= top_prog)); // R6 R7

  AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (bottom_prog > top_prog) |-> !io_fwd); // R8
endmodule

bind iowin_decoder iowin_decoder_chk #(
  .CFG_AW     (CFG_AW),
  .DATA_W     (DATA_W),
  .ADDR_W     (ADDR_W),
  .PROG_W     (PROG_W),
  .BOTTOM_OFS (BOTTOM_OFS),
  .TOP_OFS    (TOP_OFS),
  .BOTTOM_RST (BOTTOM_RST),
  .TOP_RST    (TOP_RST)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_addr    (cfg_addr),
  .cfg_wdata   (cfg_wdata),
  .cfg_rdata   (cfg_rdata),
  .io_valid    (io_valid),
  .io_addr     (io_addr),
  .io_fwd      (io_fwd),
  .bottom_prog (bottom_prog),
  .top_prog    (top_prog)
);

// File: tb/test_iowin_decoder.sv
module test_iowin_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr_en;
  logic [7:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic        io_valid;
  logic [15:0] io_addr;
  logic        io_fwd;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  iowin_decoder i_iowin_decoder (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr_en (cfg_wr_en),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .io_valid  (io_valid),
    .io_addr   (io_addr),
    .io_fwd    (io_fwd)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cfg_write(input logic [7:0] ofs, input logic [7:0] data);
    @(negedge clk);
    cfg_addr  = ofs;
    cfg_wdata = data;
    cfg_wr_en = 1'b1;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic cfg_read(input logic [7:0] ofs, output logic [7:0] data);
    cfg_addr = ofs;
    #1;
    data = cfg_rdata;
  endtask

  task automatic io_probe(input logic v, input logic [15:0] a, output logic f);
    io_valid = v;
    io_addr  = a;
    #1;
    f = io_fwd;
  endtask

  task automatic t_reset_defaults();
    logic [7:0] d;
    logic f;
    do_reset();
    cfg_read(8'h1C, d); check("R1 bottom default", 16'(d), 16'hF0);
    cfg_read(8'h1D, d); check("R1 top default", 16'(d), 16'h00);
    io_probe(1'b1, 16'hF000, f); check("R8 reset empty F000", 16'(f), 16'h0);
    io_probe(1'b1, 16'h0000, f); check("R8 reset empty 0000", 16'(f), 16'h0);
  endtask

  task automatic t_write_and_reserved();
    logic [7:0] d;
    cfg_write(8'h1C, 8'h35);
    cfg_read(8'h1C, d); check("R2 R3 bottom write 35", 16'(d), 16'h30);
    cfg_write(8'h1D, 8'h5F);
    cfg_read(8'h1D, d); check("R2 R3 top write 5F", 16'(d), 16'h50);
  endtask

  task automatic t_other_offset();
    logic [7:0] d;
    cfg_write(8'h1E, 8'hAA);
    cfg_read(8'h1E, d); check("R4 other offset read", 16'(d), 16'h00);
    cfg_read(8'h1C, d); check("R4 bottom untouched", 16'(d), 16'h30);
    cfg_read(8'h1D, d); check("R4 top untouched", 16'(d), 16'h50);
  endtask

  task automatic t_bounds();
    logic f;
    io_probe(1'b1, 16'h3000, f); check("R6 bottom edge in", 16'(f), 16'h1);
    io_probe(1'b1, 16'h2FFF, f); check("R6 below bottom", 16'(f), 16'h0);
    io_probe(1'b1, 16'h5FFF, f); check("R7 top edge in", 16'(f), 16'h1);
    io_probe(1'b1, 16'h6000, f); check("R7 above top", 16'(f), 16'h0);
  endtask

  task automatic t_valid_gate();
    logic f;
    io_probe(1'b0, 16'h4000, f); check("R5 idle in-range", 16'(f), 16'h0);
  endtask

  task automatic t_comb_response();
    logic f;
    @(negedge clk);
    io_probe(1'b1, 16'h4123, f); check("R10 same-cycle rise", 16'(f), 16'h1);
    io_probe(1'b1, 16'h7123, f); check("R10 same-cycle fall", 16'(f), 16'h0);
  endtask

  task automatic t_inverted();
    logic f;
    cfg_write(8'h1C, 8'h60);
    io_probe(1'b1, 16'h5800, f); check("R8 inverted window", 16'(f), 16'h0);
    io_probe(1'b1, 16'h6000, f); check("R8 inverted window at bottom", 16'(f), 16'h0);
  endtask

  task automatic t_cfg_mechanism();
    logic f;
    cfg_write(8'h1C, 8'h00);
    cfg_write(8'h1D, 8'h00);
    io_probe(1'b1, 16'h0CF8, f); check("R9 0CF8 forwarded", 16'(f), 16'h1);
    io_probe(1'b1, 16'h0CFC, f); check("R9 0CFC forwarded", 16'(f), 16'h1);
    io_probe(1'b1, 16'h1000, f); check("R9 1000 outside", 16'(f), 16'h0);
  endtask

  task automatic t_reset_restore();
    logic [7:0] d;
    logic f;
    cfg_write(8'h1D, 8'hC0);
    do_reset();
    cfg_read(8'h1C, d); check("R11 bottom restored", 16'(d), 16'hF0);
    cfg_read(8'h1D, d); check("R11 top restored", 16'(d), 16'h00);
    io_probe(1'b1, 16'h0CF8, f); check("R11 window empty again", 16'(f), 16'h0);
  endtask

  initial begin
    rst = 1'b1; cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    io_valid = 1'b0; io_addr = '0;
    repeat (2) @(negedge clk);
    t_reset_defaults();
    t_write_and_reserved();
    t_other_offset();
    t_bounds();
    t_valid_gate();
    t_comb_response();
    t_inverted();
    t_cfg_mechanism();
    t_reset_restore();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule